// File: doc/BRIEF.md
# Issue Window Squash and Serialization Control

This block keeps the speculation and occupancy bookkeeping for an issue window whose slots form an age-ordered ring. Each accepted insert takes the slot at the young end of the ring. Slots return to the free pool strictly in age order, as soon as the oldest occupied slot has been issued. The block reports how many slots are free and raises a full flag. Selection of instructions and operand wakeup happen elsewhere. That logic reads the per-slot flags of this block and reports each issued slot back to it.

When commit orders a rollback, it provides a boundary sequence number. The block passes that boundary straight on to the memory-ordering logic. It then walks the ring from the youngest slot toward older ones, looking at a fixed number of slots per cycle. Every unissued slot it visits whose sequence number is above the boundary, and that is not already squashed, is flagged as squashed. The walk ends at the first slot whose sequence number is at or below the boundary, or at the oldest slot. A squashed slot is not freed on the spot. It waits in a drain pool, and the issue path empties that pool by reporting the slot as issued.

An insert can be marked as serializing, which covers non-speculative instructions and stores. Such a slot is held back until commit names its sequence number in a release. The release answers with a one-cycle pulse that carries the slot index, so that the readiness check can run on that slot. When a held slot is squashed, its hold is removed.

Top module: `iw_spec_ctrl`

## Requirements
- R1: After reset the free count equals DEPTH (8 by default), and full, busy, err, the release pulse, the forward pulse and all squashed flags are 0.
- R2: Each accepted insert lowers the free count by one, visible after the next clock edge. Full reads 1 exactly when the free count is 0. Slots are filled in ring order starting from slot 0 after reset.
- R3: An insert while full or while busy is dropped, the free count does not change, and err pulses high one cycle later.
- R4: A slot returns to the free pool only after it is issued and every older slot has been returned. The ring reclaims at most one slot per cycle, one cycle after the oldest slot becomes issued. Issuing a younger slot first frees nothing.
- R5: An accepted squash flags every unissued, unsquashed slot whose sequence number is above the boundary and that lies younger than the first slot at or below the boundary. Slots at or below the boundary are left alone. The squashed flag of slot i is bit i of sq_flags.
- R6: A squash leaves slots that are already issued unflagged.
- R7: The walk examines LANES slots (4 by default) per cycle, youngest first. Busy rises one cycle after the squash is accepted and stays high for one cycle per group of LANES slots examined, counting the slot that ends the walk.
- R8: Issuing a squashed slot clears its flag, and the slot then leaves through normal in-order reclaim.
- R9: One cycle after a squash is accepted, the forward pulse is high and carries the boundary. With no squash request, it stays low.
- R10: A release whose sequence number matches a held slot clears the hold. One cycle later rel_rdy pulses with that slot's index on rel_slot.
- R11: A release that matches no held slot, including a repeat of a release already served, makes err pulse one cycle later, and rel_rdy stays low.
- R12: A squash that flags a held slot drops its hold, so a later release of that sequence number is treated as unmatched.
- R13: A squash request while busy is ignored: no forward pulse, no new walk, and err pulses one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| ins_vld | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_hold | input | 1 | Inserted instruction is serializing and must wait for a release |
| iss_vld | input | 1 | Issue report from the selection logic |
| iss_slot | input | $clog2(DEPTH) | Slot that issued |
| sq_vld | input | 1 | Squash request |
| sq_bound | input | SEQ_W | Boundary: slots above it are squashed |
| rel_vld | input | 1 | Release request from commit |
| rel_seq | input | SEQ_W | Sequence number being released |
| free_cnt | output | $clog2(DEPTH+1) | Number of free slots |
| full | output | 1 | No free slot |
| busy | output | 1 | Squash walk in progress |
| sq_flags | output | DEPTH | Per-slot squashed, awaiting drain |
| rel_rdy | output | 1 | Release served, one-cycle pulse |
| rel_slot | output | $clog2(DEPTH) | Slot freed from its hold |
| mdu_sq_vld | output | 1 | Squash forward pulse to memory ordering |
| mdu_sq_seq | output | SEQ_W | Forwarded boundary |
| err | output | 1 | Protocol error pulse |

## Verification
The assertions assume the following about the inputs. Sequence numbers rise along the ring and do not wrap while entries are live. The issue path reports only occupied slots that are unissued and no longer held, and never reports the same slot twice. No insert arrives in the same cycle as a squash request. The stimulus follows these rules by inserting increasing sequence numbers from one counter, by issuing each slot once and only after its release or squash, and by keeping inserts apart from squash requests. The error cases (insert while full, unmatched release, squash while busy) are driven on purpose, because the block defines what happens in each of them.

// File: rtl/iw_pkg.sv
`timescale 1ns/1ps
package iw_pkg;
  // per-slot state bits
  typedef struct packed {
    logic vld;   // slot occupied
    logic iss;   // issued, waiting for in-order reclaim
    logic sqd;   // squashed, waiting to be drained through issue
    logic hld;   // serializing, waiting for release
  } slot_st_t;
endpackage

// File: rtl/iw_ring_ctrl.sv
`timescale 1ns/1ps
module iw_ring_ctrl #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  output logic [$clog2(DEPTH)-1:0]   head,
  output logic [$clog2(DEPTH)-1:0]   tail,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [IW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    head_d = pop  ? head_q + IW'(1) : head_q;
    tail_d = push ? tail_q + IW'(1) : tail_q;
    cnt_d  = cnt_q + CW'(push) - CW'(pop);
    en     = push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/iw_squash_scan.sv
`timescale 1ns/1ps
module iw_squash_scan #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int LANES = 4
) (
  input  logic [$clog2(DEPTH)-1:0]        ptr,
  input  logic [$clog2(DEPTH)-1:0]        head,
  input  logic [DEPTH-1:0]                vld,
  input  logic [DEPTH-1:0]                iss,
  input  logic [DEPTH-1:0]                sqd,
  input  logic [DEPTH-1:0][SEQ_W-1:0]     seqs,
  input  logic [SEQ_W-1:0]                bound,
  output logic [DEPTH-1:0]                hit,
  output logic [$clog2(DEPTH)-1:0]        nxt_ptr,
  output logic                            done
);
  localparam int IW = $clog2(DEPTH);

  logic          alive;
  logic          inr;
  logic [IW-1:0] idx;

  // lanes walk from ptr toward older slots; first out-of-range slot or head ends the walk
  always_comb begin
    alive   = 1'b1;
    done    = 1'b0;
    hit     = '0;
    inr     = 1'b0;
    idx     = ptr;
    for (int k = 0; k < LANES; k++) begin
      idx = ptr - IW'(k);
      if (alive) begin
        inr = vld[idx] && (seqs[idx] > bound);
        if (inr && !iss[idx] && !sqd[idx]) hit[idx] = 1'b1;
        if (!inr || (idx == head)) begin
          alive = 1'b0;
          done  = 1'b1;
        end
      end
    end
    nxt_ptr = ptr - IW'(LANES);
  end
endmodule

// File: rtl/iw_hold_match.sv
`timescale 1ns/1ps
module iw_hold_match #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8
) (
  input  logic [DEPTH-1:0]               hld,
  input  logic [DEPTH-1:0][SEQ_W-1:0]    seqs,
  input  logic [SEQ_W-1:0]               key,
  output logic                           found,
  output logic [$clog2(DEPTH)-1:0]       slot
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0] m;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign m[g] = hld[g] && (seqs[g] == key);
    end
  endgenerate

  always_comb begin
    found = |m;
    slot  = '0;
    for (int i = 0; i < DEPTH; i++)
      if (m[i]) slot = slot | IW'(i);
  end
endmodule

// File: rtl/iw_spec_ctrl.sv
`timescale 1ns/1ps
module iw_spec_ctrl #(
  parameter int DEPTH = 8,   // power of two
  parameter int SEQ_W = 8,
  parameter int LANES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ins_vld,
  input  logic [SEQ_W-1:0]              ins_seq,
  input  logic                          ins_hold,
  input  logic                          iss_vld,
  input  logic [$clog2(DEPTH)-1:0]      iss_slot,
  input  logic                          sq_vld,
  input  logic [SEQ_W-1:0]              sq_bound,
  input  logic                          rel_vld,
  input  logic [SEQ_W-1:0]              rel_seq,
  output logic [$clog2(DEPTH+1)-1:0]    free_cnt,
  output logic                          full,
  output logic                          busy,
  output logic [DEPTH-1:0]              sq_flags,
  output logic                          rel_rdy,
  output logic [$clog2(DEPTH)-1:0]      rel_slot,
  output logic                          mdu_sq_vld,
  output logic [SEQ_W-1:0]              mdu_sq_seq,
  output logic                          err
);
  import iw_pkg::*;
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  slot_st_t [DEPTH-1:0]            slot_q, slot_d;
  logic [DEPTH-1:0][SEQ_W-1:0]     seq_q, seq_d;
  logic [IW-1:0]                   ptr_q, ptr_d;
  logic [SEQ_W-1:0]                bnd_q, bnd_d;
  logic                            busy_q, busy_d;
  logic                            rdy_q, err_q, mdu_q;
  logic [IW-1:0]                   rslot_q;
  logic [SEQ_W-1:0]                mseq_q;

  logic [IW-1:0]    head, tail, nxt_ptr, m_slot;
  logic [CW-1:0]    cnt;
  logic             ins_ok, sq_ok, reclaim, m_found, scan_done, rel_ok;
  logic [DEPTH-1:0] v_vld, v_iss, v_sqd, v_hld, hit;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_unpack
      assign v_vld[g] = slot_q[g].vld;
      assign v_iss[g] = slot_q[g].iss;
      assign v_sqd[g] = slot_q[g].sqd;
      assign v_hld[g] = slot_q[g].hld;
    end
  endgenerate

  assign full    = (cnt == CW'(DEPTH));
  assign ins_ok  = ins_vld && !full && !busy_q;
  assign sq_ok   = sq_vld && !busy_q;
  assign reclaim = slot_q[head].vld && slot_q[head].iss;
  assign rel_ok  = rel_vld && m_found;

  iw_ring_ctrl #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_i), .push(ins_ok), .pop(reclaim),
    .head(head), .tail(tail), .cnt(cnt)
  );

  iw_squash_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .LANES(LANES)) u_scan (
    .ptr(ptr_q), .head(head), .vld(v_vld), .iss(v_iss), .sqd(v_sqd),
    .seqs(seq_q), .bound(bnd_q), .hit(hit), .nxt_ptr(nxt_ptr), .done(scan_done)
  );

  iw_hold_match #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_match (
    .hld(v_hld), .seqs(seq_q), .key(rel_seq), .found(m_found), .slot(m_slot)
  );

  // next state of the slot array
  always_comb begin
    slot_d = slot_q;
    seq_d  = seq_q;
    if (busy_q)
      for (int i = 0; i < DEPTH; i++)
        if (hit[i]) begin
          slot_d[i].sqd = 1'b1;
          slot_d[i].hld = 1'b0;
        end
    if (rel_ok) slot_d[m_slot].hld = 1'b0;
    if (iss_vld) begin
      slot_d[iss_slot].iss = 1'b1;
      slot_d[iss_slot].sqd = 1'b0;
    end
    if (reclaim) slot_d[head] = '0;
    if (ins_ok) begin
      slot_d[tail] = '{vld: 1'b1, iss: 1'b0, sqd: 1'b0, hld: ins_hold};
      seq_d[tail]  = ins_seq;
    end
  end

  // next state of the walk
  always_comb begin
    ptr_d  = busy_q ? nxt_ptr : (tail - IW'(1));
    bnd_d  = sq_ok ? sq_bound : bnd_q;
    busy_d = busy_q ? !scan_done : sq_ok;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      slot_q <= '0;
      seq_q  <= '0;
    end else begin
      slot_q <= slot_d;
      if (ins_ok) seq_q <= seq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ptr_q  <= '0;
      bnd_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q | sq_ok) begin
      ptr_q  <= ptr_d;
      bnd_q  <= bnd_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rdy_q   <= 1'b0;
      rslot_q <= '0;
      mdu_q   <= 1'b0;
      mseq_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      rdy_q <= rel_ok;
      mdu_q <= sq_ok;
      err_q <= (ins_vld && (full || busy_q)) || (rel_vld && !m_found) || (sq_vld && busy_q);
      if (rel_ok) rslot_q <= m_slot;
      if (sq_ok)  mseq_q  <= sq_bound;
    end
  end

  assign free_cnt   = CW'(DEPTH) - cnt;
  assign busy       = busy_q;
  assign sq_flags   = v_sqd;
  assign rel_rdy    = rdy_q;
  assign rel_slot   = rslot_q;
  assign mdu_sq_vld = mdu_q;
  assign mdu_sq_seq = mseq_q;
  assign err        = err_q;
endmodule

// File: rtl/iw_spec_ctrl_sva.sv
`timescale 1ns/1ps
module iw_spec_ctrl_sva #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ins_vld,
  input logic                       sq_vld,
  input logic [SEQ_W-1:0]           sq_bound,
  input logic                       rel_vld,
  input logic [$clog2(DEPTH+1)-1:0] free_cnt,
  input logic                       full,
  input logic                       busy,
  input logic [DEPTH-1:0]           sq_flags,
  input logic                       rel_rdy,
  input logic                       mdu_sq_vld,
  input logic [SEQ_W-1:0]           mdu_sq_seq,
  input logic                       err
);
  p_full_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (free_cnt == '0));

  p_ins_nogrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld && !full && !busy) |=> (free_cnt <= $past(free_cnt)));

  p_full_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld && full) |=> err);

  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(free_cnt) <= int'($past(free_cnt)) + 1) &&
    (int'(free_cnt) + 1 >= int'($past(free_cnt))));

  p_flags_need_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((sq_flags & ~$past(sq_flags)) == '0));

  p_walk_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_vld && !busy) |=> busy);

  p_fwd_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_vld && !busy) |=> (mdu_sq_vld && (mdu_sq_seq == $past(sq_bound))));

  p_fwd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_vld |=> !mdu_sq_vld);

  p_rel_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_vld |=> !rel_rdy);

  p_busy_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_vld && busy) |=> (err && !mdu_sq_vld));
endmodule

bind iw_spec_ctrl iw_spec_ctrl_sva #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .sq_vld(sq_vld), .sq_bound(sq_bound),
  .rel_vld(rel_vld), .free_cnt(free_cnt), .full(full), .busy(busy),
  .sq_flags(sq_flags), .rel_rdy(rel_rdy), .mdu_sq_vld(mdu_sq_vld),
  .mdu_sq_seq(mdu_sq_seq), .err(err)
);

// File: tb/tb_iw_spec_ctrl.sv
`timescale 1ns/1ps
module tb_iw_spec_ctrl;
  localparam int DEPTH = 8;
  localparam int SEQ_W = 8;
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  // {seq[15:8], hold[7:4], expected free count after insert[3:0]}
  localparam logic [15:0] TBL [8] = '{
    16'h0A07, 16'h1406, 16'h1E15, 16'h2804,
    16'h3203, 16'h3C12, 16'h4601, 16'h5000
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ins_vld, ins_hold, iss_vld, sq_vld, rel_vld;
  logic [SEQ_W-1:0] ins_seq, sq_bound, rel_seq;
  logic [IW-1:0] iss_slot;
  logic [CW-1:0] free_cnt;
  logic full, busy, rel_rdy, mdu_sq_vld, err;
  logic [DEPTH-1:0] sq_flags;
  logic [IW-1:0] rel_slot;
  logic [SEQ_W-1:0] mdu_sq_seq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  iw_spec_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .LANES(4)) dut (
    .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_seq(ins_seq), .ins_hold(ins_hold),
    .iss_vld(iss_vld), .iss_slot(iss_slot), .sq_vld(sq_vld), .sq_bound(sq_bound),
    .rel_vld(rel_vld), .rel_seq(rel_seq), .free_cnt(free_cnt), .full(full), .busy(busy),
    .sq_flags(sq_flags), .rel_rdy(rel_rdy), .rel_slot(rel_slot),
    .mdu_sq_vld(mdu_sq_vld), .mdu_sq_seq(mdu_sq_seq), .err(err)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic issue(input int s);
    iss_vld = 1'b1; iss_slot = IW'(s);
    tick();
    iss_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ins_vld = 0; ins_hold = 0; ins_seq = '0; iss_vld = 0; iss_slot = '0;
    sq_vld = 0; sq_bound = '0; rel_vld = 0; rel_seq = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    chk("R1 free", int'(free_cnt), DEPTH);
    chk("R1 full", int'(full), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 flags", int'(sq_flags), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 rel_rdy", int'(rel_rdy), 0);
    chk("R1 fwd", int'(mdu_sq_vld), 0);

    // table walk: fill the ring
    for (int i = 0; i < 8; i++) begin
      ins_vld = 1'b1; ins_seq = TBL[i][15:8]; ins_hold = TBL[i][4];
      tick();
      ins_vld = 1'b0;
      chk("R2 free after insert", int'(free_cnt), int'(TBL[i][3:0]));
    end
    chk("R2 full", int'(full), 1);

    // insert while full
    ins_vld = 1'b1; ins_seq = 8'd90; ins_hold = 1'b0;
    tick();
    ins_vld = 1'b0;
    chk("R3 err", int'(err), 1);
    chk("R3 free", int'(free_cnt), 0);

    // release of unknown seq
    rel_vld = 1'b1; rel_seq = 8'd99;
    tick();
    rel_vld = 1'b0;
    chk("R11 err", int'(err), 1);
    chk("R11 rel_rdy", int'(rel_rdy), 0);

    // release held seq 30 (slot 2)
    rel_vld = 1'b1; rel_seq = 8'd30;
    tick();
    rel_vld = 1'b0;
    chk("R10 rel_rdy", int'(rel_rdy), 1);
    chk("R10 rel_slot", int'(rel_slot), 2);
    chk("R10 err", int'(err), 0);

    // repeat release
    rel_vld = 1'b1; rel_seq = 8'd30;
    tick();
    rel_vld = 1'b0;
    chk("R11 repeat err", int'(err), 1);

    // younger issued first: no reclaim
    issue(1);
    tick(); tick();
    chk("R4 no reclaim out of order", int'(free_cnt), 0);
    issue(0);
    chk("R4 free at issue edge", int'(free_cnt), 0);
    tick();
    chk("R4 first reclaim", int'(free_cnt), 1);
    tick();
    chk("R4 second reclaim", int'(free_cnt), 2);

    issue(3);

    // squash above 35: slots 4..7 flagged, slot 3 issued, slot 2 at boundary
    sq_vld = 1'b1; sq_bound = 8'd35;
    tick();
    chk("R9 fwd", int'(mdu_sq_vld), 1);
    chk("R9 fwd seq", int'(mdu_sq_seq), 35);
    chk("R7 busy rise", int'(busy), 1);
    sq_bound = 8'd0;   // second request while busy
    tick();
    sq_vld = 1'b0;
    chk("R13 err", int'(err), 1);
    chk("R13 no fwd", int'(mdu_sq_vld), 0);
    chk("R7 busy second group", int'(busy), 1);
    tick();
    chk("R7 busy end", int'(busy), 0);
    chk("R5 R6 flags", int'(sq_flags), 'hF0);
    tick();
    chk("R13 ignored walk", int'(sq_flags), 'hF0);

    // squashed held slot loses its hold
    rel_vld = 1'b1; rel_seq = 8'd60;
    tick();
    rel_vld = 1'b0;
    chk("R12 err", int'(err), 1);
    chk("R12 rel_rdy", int'(rel_rdy), 0);

    // drain
    issue(2);
    issue(4);
    chk("R8 flag cleared", int'(sq_flags), 'hE0);
    issue(5); issue(6); issue(7);
    repeat (8) tick();
    chk("R8 free", int'(free_cnt), DEPTH);
    chk("R8 flags", int'(sq_flags), 0);
    chk("R8 full", int'(full), 0);

    // short walk: two entries, one group
    ins_vld = 1'b1; ins_hold = 1'b0; ins_seq = 8'd100;
    tick();
    ins_seq = 8'd110;
    tick();
    ins_vld = 1'b0;
    sq_vld = 1'b1; sq_bound = 8'd105;
    tick();
    sq_vld = 1'b0;
    chk("R7 short busy", int'(busy), 1);
    tick();
    chk("R7 short done", int'(busy), 0);
    chk("R5 short flags", int'(sq_flags), 'h02);
    issue(0); issue(1);
    repeat (4) tick();
    chk("R4 final free", int'(free_cnt), DEPTH);

    finish_run();
  end
endmodule